// File: doc/BRIEF.md
# NAND Boot Page Loader

This block is a hardware sequencer that copies a contiguous image from 8-bit NAND flash into system memory at boot. When `start` is pulsed in idle, it samples a destination base, a byte count, a start page and a page size. It then enables the flash interface with chip enable asserted, resets the device, and waits for the device to report ready.

For each page it sends the page read command and four address bytes built from the byte offset `page * page_size`. It waits for ready again and then reads the whole page one byte per cycle. Every byte goes out on the memory write port at an address that rises by one per byte. Pages follow one another until the requested count is covered. The last page is always read in full.

When the count is covered, chip enable is released and the interface is switched off. `done` then pulses for one cycle. The loader has no failure exit.

Top module: `nand_boot_loader`

## Requirements
- R1: After reset the loader is idle: `nf_ce_n`=1, `ctrl_en`=0, `done`=0, and no strobe (`nf_we`, `nf_re`, `mem_we`) is active.
- R2: A `start` in idle switches `ctrl_en` on with `nf_ce_n` low. The first byte issued is the command 0xFF, sent with `nf_cle`=1.
- R3: After the reset command, and after the last address byte of each page, no strobe is issued until `nf_rdy` is sampled at 1 (1 = ready, 0 = busy).
- R4: Each page starts with the command 0x00. Four address bytes follow on `nf_ale`, in this order: off[7:0], off[16:9], off[24:17], {1'b0, off[31:25]}, where off = page * page_size (32 bits). Offset bit 8 is never sent.
- R5: A command or address write holds `nf_we`, the lane (`nf_cle` or `nf_ale`, exactly one of them) and `nf_dout` steady until `nf_ack` is seen in the same cycle as `nf_we`.
- R6: A data read is one `nf_re` cycle. In that cycle `mem_we`=1, `mem_wdata`=`nf_din`, and `mem_addr` = destination base + bytes already read in this run.
- R7: Pages are read from the start page upward until the byte count is covered. The total number of bytes written is ceil(count / page_size) * page_size. A count of 0 performs the device reset and then reads nothing.
- R8: At the end, `nf_ce_n` returns to 1 while `ctrl_en` is still 1. In the next cycle `ctrl_en`=0 and `done`=1 for exactly one cycle.
- R9: `start` has no effect while a run is in progress, including in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken only when idle) |
| dst_base | input | AW | First destination address |
| byte_count | input | 32 | Bytes requested |
| first_page | input | PG_W | First page to read |
| page_size | input | PS_W | Bytes per page (non-zero) |
| nf_rdy | input | 1 | Flash ready/busy, 1 = ready |
| nf_ack | input | 1 | Flash interface accepts the current command/address write |
| nf_din | input | 8 | Read data from the flash |
| ctrl_en | output | 1 | Flash interface enabled |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command lane select |
| nf_ale | output | 1 | Address lane select |
| nf_we | output | 1 | Command/address write strobe |
| nf_dout | output | 8 | Command or address byte |
| nf_re | output | 1 | Data read strobe |
| mem_we | output | 1 | Destination write enable |
| mem_addr | output | AW | Destination address |
| mem_wdata | output | 8 | Destination write data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse and a new `start`. The bench raises `start` exactly in the cycle where it sees `done`. It then watches the next several cycles for any chip enable or strobe activity, and judges the collision by requiring that the loader stays idle. It also fires a stray `start` with different inputs in the middle of a run. The addresses and data already expected for that run must be unchanged.

// File: rtl/nand_boot_loader.sv
module nand_boot_loader #(
  parameter int AW   = 32,
  parameter int PG_W = 24,
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   dst_base,
  input  logic [31:0]     byte_count,
  input  logic [PG_W-1:0] first_page,
  input  logic [PS_W-1:0] page_size,
  input  logic            nf_rdy,
  input  logic            nf_ack,
  input  logic [7:0]      nf_din,
  output logic            ctrl_en,
  output logic            nf_ce_n,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_we,
  output logic [7:0]      nf_dout,
  output logic            nf_re,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            busy,
  output logic            done
);
  typedef enum logic [3:0] {
    S_IDLE, S_EN, S_RCMD, S_RWAIT, S_PCMD, S_ADDR,
    S_PWAIT, S_DATA, S_NEXT, S_OFF, S_FIN
  } st_t;

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_READ  = 8'h00;

  st_t             st;
  logic [PG_W-1:0] page_q;
  logic [PS_W-1:0] psz_q, col_q;
  logic [31:0]     rem_q;
  logic [AW-1:0]   dst_q;
  logic [1:0]      aidx;
  logic [31:0]     off;
  logic [7:0]      abyte;

  assign off = 32'(page_q) * 32'(psz_q);

  always_comb begin
    case (aidx)
      2'd0:    abyte = off[7:0];
      2'd1:    abyte = off[16:9];
      2'd2:    abyte = off[24:17];
      default: abyte = {1'b0, off[31:25]};
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign ctrl_en   = !(st inside {S_IDLE, S_FIN});
  assign nf_ce_n   = (st inside {S_IDLE, S_OFF, S_FIN});
  assign nf_cle    = (st inside {S_RCMD, S_PCMD});
  assign nf_ale    = (st == S_ADDR);
  assign nf_we     = nf_cle | nf_ale;
  assign nf_dout   = (st == S_RCMD) ? CMD_RESET : (st == S_PCMD) ? CMD_READ : abyte;
  assign nf_re     = (st == S_DATA);
  assign mem_we    = nf_re;
  assign mem_addr  = dst_q;
  assign mem_wdata = nf_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      page_q <= '0;
      psz_q  <= '0;
      col_q  <= '0;
      rem_q  <= '0;
      dst_q  <= '0;
      aidx   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          page_q <= first_page;
          psz_q  <= page_size;
          rem_q  <= byte_count;
          dst_q  <= dst_base;
          st     <= S_EN;
        end
        S_EN:    st <= S_RCMD;
        S_RCMD:  if (nf_ack) st <= S_RWAIT;
        S_RWAIT: if (nf_rdy) st <= (rem_q == '0) ? S_OFF : S_PCMD;
        S_PCMD:  if (nf_ack) begin
          aidx <= '0;
          st   <= S_ADDR;
        end
        S_ADDR:  if (nf_ack) begin
          aidx <= aidx + 2'd1;
          if (aidx == 2'd3) st <= S_PWAIT;
        end
        S_PWAIT: if (nf_rdy) begin
          col_q <= '0;
          st    <= S_DATA;
        end
        S_DATA: begin
          dst_q <= dst_q + AW'(1);
          col_q <= col_q + PS_W'(1);
          if (col_q == psz_q - PS_W'(1)) st <= S_NEXT;
        end
        S_NEXT: begin
          if (rem_q <= 32'(psz_q)) begin
            rem_q <= '0;
            st    <= S_OFF;
          end else begin
            rem_q  <= rem_q - 32'(psz_q);
            page_q <= page_q + PG_W'(1);
            st     <= S_PCMD;
          end
        end
        S_OFF:   st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_boot_loader_chk.sv
module nand_boot_loader_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_en,
  input logic          nf_ce_n,
  input logic          nf_cle,
  input logic          nf_ale,
  input logic          nf_we,
  input logic [7:0]    nf_dout,
  input logic          nf_ack,
  input logic          nf_re,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done
);
  always_comb begin
    if (!rst_n) a_r1_idle_in_reset: assert (nf_ce_n && !ctrl_en && !done && !nf_we && !nf_re);
  end

  a_r2_enable_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> !nf_ce_n && !nf_we && !nf_re);

  a_r5_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    nf_we && !nf_ack |=> nf_we && $stable(nf_dout) && $stable(nf_cle));

  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    nf_we |-> (nf_cle ^ nf_ale));

  a_r6_read_selected: assert property (@(posedge clk) disable iff (!rst_n)
    nf_re |-> !nf_ce_n && ctrl_en && mem_we && !nf_we);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + AW'(1));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_off: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> nf_ce_n && !ctrl_en && !nf_we && !nf_re && busy);

  a_r8_ce_before_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |-> $past(nf_ce_n));
endmodule

bind nand_boot_loader nand_boot_loader_chk #(.AW(AW)) u_chk (.*);

// File: tb/nand_boot_loader_tb_top.sv
module nand_boot_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, PG_W = 24, PS_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] dst_base = '0;
  logic [31:0] byte_count = '0;
  logic [PG_W-1:0] first_page = '0;
  logic [PS_W-1:0] page_size = 16'd16;
  logic nf_rdy, nf_ack, ack_en = 1'b0;
  logic [7:0] nf_din;
  logic ctrl_en, nf_ce_n, nf_cle, nf_ale, nf_we, nf_re, mem_we, busy, done;
  logic [7:0] nf_dout, mem_wdata;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_boot_loader #(.AW(AW), .PG_W(PG_W), .PS_W(PS_W)) dut_i (.*);

  // run context (expected values)
  logic [AW-1:0] e_base;
  logic [31:0]   e_count;
  logic [PG_W-1:0] e_fp;
  logic [PS_W-1:0] e_psz;
  int pg_idx, col, nwr, aidx, busy_cnt, ncmd;
  logic [31:0] cur_off;

  function automatic logic [7:0] fbyte(input logic [31:0] x);
    logic [31:0] h;
    h = x * 32'h9E3779B1;
    return h[31:24] ^ x[7:0];
  endfunction

  function automatic logic [7:0] exp_abyte(input logic [31:0] o, input int i);
    case (i)
      0: return o[7:0];
      1: return o[16:9];
      2: return o[24:17];
      default: return {1'b0, o[31:25]};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  assign nf_rdy = (busy_cnt == 0);
  assign nf_ack = nf_we & ack_en;
  assign cur_off = 32'(e_fp + PG_W'(pg_idx - 1)) * 32'(e_psz);
  assign nf_din = fbyte(cur_off + 32'(col));

  // flash model: state updates on the rising edge
  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (nf_we && nf_ack) begin
      if (nf_cle) begin
        ncmd <= ncmd + 1;
        if (nf_dout == 8'hFF) busy_cnt <= 1 + int'($urandom % 6);
        else begin pg_idx <= pg_idx + 1; aidx <= 0; col <= 0; end
      end else begin
        aidx <= aidx + 1;
        if (aidx == 3) busy_cnt <= 1 + int'($urandom % 8);
      end
    end
    if (nf_re) col <= col + 1;
  end

  // monitor: samples away from the rising edge
  always @(negedge clk) begin
    ack_en <= ($urandom % 3) != 0;
    if (rst_n && busy_cnt != 0)
      if (nf_we || nf_re) check(1'b0, "R3 strobe while busy", 1, 0);
    if (rst_n && nf_we && nf_ack) begin
      if (nf_cle) begin
        if (ncmd == 0) check(nf_dout == 8'hFF && !nf_ce_n && ctrl_en, "R2 first command", nf_dout, 8'hFF);
        else check(nf_dout == 8'h00, "R4 page command", nf_dout, 8'h00);
      end else begin
        check(nf_dout == exp_abyte(cur_off, aidx), "R4 address byte", nf_dout, exp_abyte(cur_off, aidx));
      end
    end
    if (rst_n && nf_re) begin
      check(mem_we && mem_addr == e_base + AW'(nwr), "R6 write address", mem_addr, e_base + AW'(nwr));
      check(mem_wdata == fbyte(cur_off + 32'(col)), "R6 write data", mem_wdata, fbyte(cur_off + 32'(col)));
      nwr++;
    end
  end

  task automatic run(input logic [AW-1:0] b, input logic [31:0] c, input logic [PG_W-1:0] fp,
                     input logic [PS_W-1:0] ps, input bit collide);
    int n, lim, exp_n, quiet;
    @(negedge clk);
    e_base = b; e_count = c; e_fp = fp; e_psz = ps;
    nwr = 0; ncmd = 0; pg_idx = 0;
    dst_base = b; byte_count = c; first_page = fp; page_size = ps;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && ctrl_en && !nf_ce_n, "R2 enable after start", {busy, ctrl_en, nf_ce_n}, 3'b110);
    repeat (3) @(negedge clk);
    dst_base = ~b; byte_count = 32'd5; first_page = fp + 7; page_size = ps + 3; start = 1'b1; // R9
    @(negedge clk);
    start = 1'b0;
    lim = 20000; n = 0;
    while (!done && n < lim) begin
      if (nf_ce_n && ctrl_en) check(!nf_we && !nf_re, "R8 ce released before off", 1, 0);
      @(negedge clk); n++;
    end
    check(n < lim, "R8 done reached", n, lim);
    check(!ctrl_en && nf_ce_n, "R8 off at done", {ctrl_en, nf_ce_n}, 2'b01);
    exp_n = (c == 0) ? 0 : int'(((c + 32'(ps) - 1) / 32'(ps)) * 32'(ps));
    check(nwr == exp_n, "R7 byte total", nwr, exp_n);
    check(pg_idx == exp_n / int'(ps), "R7 page total", pg_idx, exp_n / int'(ps));
    if (collide) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done, "R8 done one cycle", done, 0);
    quiet = 1;
    repeat (6) begin
      if (!nf_ce_n || nf_we || nf_re || busy) quiet = 0;
      @(negedge clk);
    end
    check(quiet == 1, "R9 start ignored at done", quiet, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    busy_cnt = 0; col = 0; pg_idx = 0; nwr = 0; aidx = 0; ncmd = 0;
    repeat (3) @(negedge clk);
    check(nf_ce_n && !ctrl_en && !done && !nf_we && !nf_re && !mem_we, "R1 reset state",
          {nf_ce_n, ctrl_en, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h1000, 32'd0, 24'd3, 16'd16, 1'b0);          // R7 zero count
    run(32'h2000, 32'd1, 24'd5, 16'd8, 1'b1);           // R7 partial last page
    run(32'h3000, 32'd64, 24'd2, 16'd32, 1'b0);         // R7 exact multiple
    run(32'h4000, 32'd3, 24'hFFFFF, 16'd512, 1'b1);     // R4 high offset bits
    run(32'h5000, 32'd40, 24'h000123, 16'd300, 1'b0);   // R4 offset bit 8 skipped
    for (int k = 0; k < 8; k++) begin
      logic [PS_W-1:0] ps;
      ps = PS_W'(4 + ($urandom % 60));
      run($urandom, 32'($urandom % (3 * ps + 1)), PG_W'($urandom), ps, k[0]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule